// File: doc/BRIEF.md
# Bank Auto-Precharge Timing Controller

This block follows one bank of a double-data-rate SDRAM-style memory through its open and close cycle. It also screens commands aimed at the other banks for the one conflict that depends on this bank. Each cycle it takes a decoded command, the bank address and an auto-close flag. The flag stands for the address bit that turns a read or write into its self-precharging form. From these it keeps a state machine and a set of timers, all sized at elaboration. The timers enforce row-to-column delay, minimum row-open time, write recovery and precharge duration.

Once a self-closing read or write is accepted, the block works out when the bank's internal precharge should begin. An interlock holds that start back until the minimum row-open time since activation has passed. The block emits a one-cycle pulse when the internal precharge begins and raises a ready flag once the bank is idle again. A memory controller uses it as the authority on whether a command to this bank, or a column command to another bank, may go out in a given cycle. Any command it refuses is flagged one cycle later and leaves the bank's state alone.

Top module: `bank_ap_ctrl`

## Requirements
- R1: After reset, and after each precharge completes, the state is IDLE (code 0). In IDLE, `ready_o` is 1. In every other state, `ready_o` is 0.
- R2: An ACTIVATE (cmd 1) to the tracked bank from IDLE moves it to ACTIVATING (code 1). The bank enters ACTIVE (code 2) exactly T_RCD cycles after the ACTIVATE cycle.
- R3: A READ (cmd 2) or WRITE (cmd 3) to the tracked bank while it is IDLE or ACTIVATING is illegal. `illegal_o` is 1 in the following cycle and the state is not changed by it.
- R4: In ACTIVE, a READ or WRITE with `ap_i` low is legal and the bank stays ACTIVE. A PRECHARGE (cmd 4) is legal and leads to PRECHARGING (code 6) the next cycle with no start pulse. An ACTIVATE is illegal.
- R5: A READ with `ap_i` high in ACTIVE enters READ_AP (code 3). The internal precharge begins BURST_LEN/2 cycles after the command cycle.
- R6: A WRITE with `ap_i` high in ACTIVE enters WRITE_AP (code 4). The internal precharge begins 1 + BURST_LEN/2 + T_WR cycles after the command cycle, which covers the one-cycle write latency, the burst and write recovery.
- R7: If the minimum row-open time is not yet met when the precharge would begin, the bank waits in WAIT_TRAS (code 5). The precharge then begins exactly T_RAS cycles after the ACTIVATE cycle.
- R8: `pre_start_o` is a one-cycle pulse in the first PRECHARGING cycle of an automatic close. PRECHARGING lasts T_RP cycles and then returns to IDLE.
- R9: In WRITE_AP, WAIT_TRAS or PRECHARGING, every command to the tracked bank is illegal. In READ_AP, every command to it except a READ with `ap_i` high is illegal.
- R10: A READ with `ap_i` high to the tracked bank while in READ_AP is legal. It moves the precharge start to BURST_LEN/2 cycles after this latest command.
- R11: In the first cycle after a self-closing read is accepted, a READ or WRITE to any other bank is illegal.
- R12: ACTIVATE and PRECHARGE to other banks are always legal. Column commands to other banks are legal outside the slot named in R11.
- R13: A synchronous active-high `rst` returns the bank to IDLE from any state and clears `illegal_o` and `pre_start_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd_i | input | 3 | Command: 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE, others NOP |
| bank_i | input | BANK_W | Bank address of the command |
| ap_i | input | 1 | Auto-close flag for READ and WRITE |
| state_o | output | 3 | Tracked bank state code |
| pre_start_o | output | 1 | Pulse on the first cycle of an automatic precharge |
| ready_o | output | 1 | Tracked bank is idle |
| illegal_o | output | 1 | Command of the previous cycle was refused |

## Verification
The assertions assume commands arrive at most one per cycle and that unused command codes act as no-ops. The row-open counter is taken to restart only on an accepted ACTIVATE. The interlock property relies on each automatic close having been preceded by an activation of this bank since reset. The directed stimulus always resets first, activates the tracked bank before any column command, and holds the bus at NOP between scripted commands. Every timing check is therefore anchored to a known activation cycle.

// File: rtl/bap_pkg.sv
`timescale 1ns/1ps
package bap_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_ACTIVATING = 3'd1,
    ST_ACTIVE     = 3'd2,
    ST_READ_AP    = 3'd3,
    ST_WRITE_AP   = 3'd4,
    ST_WAIT_TRAS  = 3'd5,
    ST_PRECH      = 3'd6
  } bank_st_e;

  // cycles from a self-closing read command to precharge start
  function automatic int rd_close_delay(int burst_len);
    return burst_len / 2;
  endfunction

  // write latency of one cycle, burst beats on both edges, then recovery
  function automatic int wr_close_delay(int burst_len, int t_wr);
    return 1 + burst_len / 2 + t_wr;
  endfunction

  function automatic int max_of4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/bap_ras_tracker.sv
`timescale 1ns/1ps
module bap_ras_tracker #(
  parameter int T_RAS = 7,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act_fire,
  output logic [CW-1:0] elapsed
);
  // cycles since the accepted ACTIVATE, saturating at T_RAS
  always_ff @(posedge clk) begin
    if (rst)
      elapsed <= '0;
    else if (act_fire)
      elapsed <= CW'(1);
    else if (elapsed != '0 && elapsed < CW'(T_RAS))
      elapsed <= elapsed + CW'(1);
  end
endmodule

// File: rtl/bap_cmd_legal.sv
`timescale 1ns/1ps
module bap_cmd_legal
  import bap_pkg::*;
#(
  parameter int BANK_W     = 2,
  parameter int TRACK_BANK = 0,
  parameter int RD_DLY     = 2,
  parameter int CW         = 4
) (
  input  logic [2:0]        cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic              ap,
  input  logic [2:0]        state,
  input  logic [CW-1:0]     close_cnt,
  output logic              own_hit,
  output logic              own_ok,
  output logic              first_slot,
  output logic              illegal
);
  logic is_act, is_rd, is_wr, is_pre, is_col, active_cmd, own_bad, other_bad;

  assign is_act     = (cmd == CMD_ACT);
  assign is_rd      = (cmd == CMD_RD);
  assign is_wr      = (cmd == CMD_WR);
  assign is_pre     = (cmd == CMD_PRE);
  assign is_col     = is_rd | is_wr;
  assign active_cmd = is_act | is_col | is_pre;
  assign own_hit    = (bank == BANK_W'(TRACK_BANK));
  assign first_slot = (state == ST_READ_AP) && (close_cnt == CW'(RD_DLY - 1));

  always_comb begin
    own_bad = 1'b0;
    unique case (state)
      ST_IDLE:    own_bad = is_col;
      ST_ACTIVE:  own_bad = is_act;
      ST_READ_AP: own_bad = active_cmd && !(is_rd && ap);
      default:    own_bad = active_cmd;
    endcase
  end

  assign other_bad = first_slot && is_col;
  assign illegal   = own_hit ? own_bad : other_bad;
  assign own_ok    = own_hit && active_cmd && !own_bad;
endmodule

// File: rtl/bank_ap_ctrl.sv
`timescale 1ns/1ps
module bank_ap_ctrl
  import bap_pkg::*;
#(
  parameter int BANK_W     = 2,
  parameter int TRACK_BANK = 0,
  parameter int T_RCD      = 3,
  parameter int T_RAS      = 7,
  parameter int T_WR       = 2,
  parameter int T_RP       = 3,
  parameter int BURST_LEN  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              ap_i,
  output logic [2:0]        state_o,
  output logic              pre_start_o,
  output logic              ready_o,
  output logic              illegal_o
);
  localparam int RD_DLY  = rd_close_delay(BURST_LEN);
  localparam int WR_DLY  = wr_close_delay(BURST_LEN, T_WR);
  localparam int CNT_MAX = max_of4(T_RAS, WR_DLY, T_RP, RD_DLY);
  localparam int CW      = $clog2(CNT_MAX + 1);

  bank_st_e      state, state_n;
  logic [CW-1:0] close_cnt, close_cnt_n;
  logic [CW-1:0] ras_elapsed;
  logic          own_hit, own_ok, first_slot, illegal_c;
  logic          act_fire, rdap_fire, wrap_fire, pre_fire;
  logic          timer_last, rcd_done_next, ras_ok_next, enter_auto;

  bap_cmd_legal #(
    .BANK_W(BANK_W), .TRACK_BANK(TRACK_BANK), .RD_DLY(RD_DLY), .CW(CW)
  ) u_legal (
    .cmd(cmd_i), .bank(bank_i), .ap(ap_i), .state(state),
    .close_cnt(close_cnt), .own_hit(own_hit), .own_ok(own_ok),
    .first_slot(first_slot), .illegal(illegal_c)
  );

  bap_ras_tracker #(.T_RAS(T_RAS), .CW(CW)) u_ras (
    .clk(clk), .rst(rst), .act_fire(act_fire), .elapsed(ras_elapsed)
  );

  // named command events, only for accepted commands to this bank
  assign act_fire  = own_ok && (cmd_i == CMD_ACT) && (state == ST_IDLE);
  assign rdap_fire = own_ok && (cmd_i == CMD_RD) && ap_i;
  assign wrap_fire = own_ok && (cmd_i == CMD_WR) && ap_i;
  assign pre_fire  = own_ok && (cmd_i == CMD_PRE) && (state == ST_ACTIVE);

  assign timer_last    = (close_cnt == CW'(1));
  assign rcd_done_next = (ras_elapsed >= CW'(T_RCD - 1));
  assign ras_ok_next   = (ras_elapsed >= CW'(T_RAS - 1));

  always_comb begin
    state_n     = state;
    close_cnt_n = (close_cnt != '0) ? close_cnt - CW'(1) : close_cnt;
    unique case (state)
      ST_IDLE: begin
        if (act_fire) state_n = (T_RCD <= 1) ? ST_ACTIVE : ST_ACTIVATING;
      end
      ST_ACTIVATING: begin
        if (rcd_done_next) state_n = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (rdap_fire) begin
          state_n     = ST_READ_AP;
          close_cnt_n = CW'(RD_DLY - 1);
        end else if (wrap_fire) begin
          state_n     = ST_WRITE_AP;
          close_cnt_n = CW'(WR_DLY - 1);
        end else if (pre_fire) begin
          state_n     = ST_PRECH;
          close_cnt_n = CW'(T_RP);
        end
      end
      ST_READ_AP, ST_WRITE_AP: begin
        if (rdap_fire) begin
          close_cnt_n = CW'(RD_DLY - 1);
        end else if (timer_last) begin
          state_n     = ras_ok_next ? ST_PRECH : ST_WAIT_TRAS;
          close_cnt_n = CW'(T_RP);
        end
      end
      ST_WAIT_TRAS: begin
        if (ras_ok_next) begin
          state_n     = ST_PRECH;
          close_cnt_n = CW'(T_RP);
        end
      end
      ST_PRECH: begin
        if (timer_last) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign enter_auto = (state_n == ST_PRECH) &&
                      (state == ST_READ_AP || state == ST_WRITE_AP ||
                       state == ST_WAIT_TRAS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      close_cnt   <= '0;
      pre_start_o <= 1'b0;
      illegal_o   <= 1'b0;
    end else begin
      state       <= state_n;
      close_cnt   <= close_cnt_n;
      pre_start_o <= enter_auto;
      illegal_o   <= illegal_c;
    end
  end

  assign state_o = state;
  assign ready_o = (state == ST_IDLE);
endmodule

// File: rtl/bap_chk.sv
`timescale 1ns/1ps
module bap_chk
  import bap_pkg::*;
#(
  parameter int BANK_W     = 2,
  parameter int TRACK_BANK = 0,
  parameter int T_RCD      = 3,
  parameter int T_RAS      = 7,
  parameter int BURST_LEN  = 4,
  parameter int CW         = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        cmd_i,
  input logic [BANK_W-1:0] bank_i,
  input logic [2:0]        state_o,
  input logic              pre_start_o,
  input logic              illegal_o,
  input logic [CW-1:0]     ras_elapsed
);
  initial begin
    param_sane_chk: assert (T_RCD >= 1 && T_RCD <= T_RAS && BURST_LEN >= 4)
      else $error("parameter set outside supported range");
  end

  // R2
  rcd_before_active_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_ACTIVE) |-> (ras_elapsed >= CW'(T_RCD)));

  // R3
  early_col_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_ACTIVATING && cmd_i == CMD_RD && bank_i == BANK_W'(TRACK_BANK))
      |=> illegal_o);

  // R7
  ras_interlock_chk: assert property (@(posedge clk) disable iff (rst)
    pre_start_o |-> (ras_elapsed >= CW'(T_RAS)));

  // R7
  wait_tras_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_WAIT_TRAS) |-> (ras_elapsed < CW'(T_RAS)));

  // R8
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pre_start_o |=> !pre_start_o);

  // R8
  start_in_prech_chk: assert property (@(posedge clk) disable iff (rst)
    pre_start_o |-> (state_o == ST_PRECH));

  // R8
  prech_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_PRECH) |=> (state_o == ST_PRECH || state_o == ST_IDLE));
endmodule

bind bank_ap_ctrl bap_chk #(
  .BANK_W(BANK_W), .TRACK_BANK(TRACK_BANK), .T_RCD(T_RCD),
  .T_RAS(T_RAS), .BURST_LEN(BURST_LEN), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .cmd_i(cmd_i), .bank_i(bank_i),
  .state_o(state_o), .pre_start_o(pre_start_o), .illegal_o(illegal_o),
  .ras_elapsed(ras_elapsed)
);

// File: tb/bank_ap_ctrl_tb.sv
`timescale 1ns/1ps
module bank_ap_ctrl_tb;
  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4;
  localparam int S_IDLE = 0, S_ACTG = 1, S_ACTV = 2, S_RDAP = 3,
                 S_WRAP = 4, S_WTRAS = 5, S_PRE = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cmd = NOP;
  logic [1:0] bank = 2'd0;
  logic       ap = 1'b0;
  logic [2:0] state_o;
  logic       pre_start_o, ready_o, illegal_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  bank_ap_ctrl #(
    .BANK_W(2), .TRACK_BANK(0), .T_RCD(3), .T_RAS(7),
    .T_WR(2), .T_RP(3), .BURST_LEN(4)
  ) u_dut (
    .clk(clk), .rst(rst), .cmd_i(cmd), .bank_i(bank), .ap_i(ap),
    .state_o(state_o), .pre_start_o(pre_start_o),
    .ready_o(ready_o), .illegal_o(illegal_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic tick(input logic [2:0] c, input logic [1:0] b, input logic a);
    cmd = c; bank = b; ap = a;
    @(negedge clk);
    cmd = NOP; bank = 2'd0; ap = 1'b0;
    cyc++;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) tick(NOP, 2'd0, 1'b0);
  endtask

  task automatic do_reset();
    rst = 1'b1; cmd = NOP; bank = 2'd0; ap = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    cyc = 0;
  endtask

  // activate bank 0 in cycle 0, sit until cycle 7, issue read with close flag
  task automatic open_and_read_close();
    tick(ACT, 2'd0, 1'b0);
    wait_to(7);
    tick(RD, 2'd0, 1'b1);
    chk("R5 state after read-close", state_o, S_RDAP);
  endtask

  task automatic t_reset_idle();
    do_reset();
    chk("R1 reset state", state_o, S_IDLE);
    chk("R1 reset ready", ready_o, 1);
    chk("R13 reset illegal", illegal_o, 0);
    chk("R13 reset start", pre_start_o, 0);
    tick(RD, 2'd0, 1'b0);
    chk("R3 read in idle flagged", illegal_o, 1);
    chk("R3 idle unchanged", state_o, S_IDLE);
  endtask

  task automatic t_rcd_and_ras();
    do_reset();
    tick(ACT, 2'd0, 1'b0);
    chk("R2 activating", state_o, S_ACTG);
    chk("R1 not ready", ready_o, 0);
    tick(RD, 2'd0, 1'b0);
    chk("R3 early read flagged", illegal_o, 1);
    chk("R3 early read no change", state_o, S_ACTG);
    tick(NOP, 2'd0, 1'b0);
    chk("R2 active at T_RCD", state_o, S_ACTV);
    chk("R3 flag clears", illegal_o, 0);
    tick(RD, 2'd0, 1'b1);
    chk("R5 read-close state", state_o, S_RDAP);
    wait_to(5);
    chk("R7 waits for row time", state_o, S_WTRAS);
    wait_to(6);
    chk("R7 still waiting", state_o, S_WTRAS);
    chk("R7 no early start", pre_start_o, 0);
    wait_to(7);
    chk("R7 start at T_RAS", pre_start_o, 1);
    chk("R8 precharging", state_o, S_PRE);
    tick(ACT, 2'd0, 1'b0);
    chk("R8 pulse one cycle", pre_start_o, 0);
    chk("R9 activate while precharging", illegal_o, 1);
    chk("R9 state kept", state_o, S_PRE);
    wait_to(10);
    chk("R8 idle after T_RP", state_o, S_IDLE);
    chk("R1 ready again", ready_o, 1);
  endtask

  task automatic t_write_close();
    do_reset();
    tick(ACT, 2'd0, 1'b0);
    wait_to(5);
    tick(WR, 2'd0, 1'b1);
    chk("R6 write-close state", state_o, S_WRAP);
    tick(PRE, 2'd0, 1'b0);
    chk("R9 precharge during write-close", illegal_o, 1);
    chk("R9 write-close kept", state_o, S_WRAP);
    wait_to(9);
    chk("R6 no start before recovery", pre_start_o, 0);
    chk("R6 still write-close", state_o, S_WRAP);
    wait_to(10);
    chk("R6 start after recovery", pre_start_o, 1);
    chk("R6 precharging", state_o, S_PRE);
    wait_to(12);
    chk("R8 still precharging", state_o, S_PRE);
    wait_to(13);
    chk("R8 idle", state_o, S_IDLE);
  endtask

  task automatic t_interrupt();
    do_reset();
    open_and_read_close();
    tick(RD, 2'd0, 1'b1);
    chk("R10 interrupt legal", illegal_o, 0);
    chk("R10 start pushed back", pre_start_o, 0);
    chk("R10 still read-close", state_o, S_RDAP);
    tick(NOP, 2'd0, 1'b0);
    chk("R10 start after last read", pre_start_o, 1);
    wait_to(13);
    chk("R10 idle", state_o, S_IDLE);
  endtask

  task automatic t_other_bank_col();
    do_reset();
    open_and_read_close();
    tick(RD, 2'd2, 1'b0);
    chk("R11 other-bank read in first slot", illegal_o, 1);
    chk("R11 own bank closes on time", pre_start_o, 1);
  endtask

  task automatic t_other_bank_free();
    do_reset();
    open_and_read_close();
    tick(ACT, 2'd1, 1'b0);
    chk("R12 other-bank activate legal", illegal_o, 0);
    chk("R12 own start unaffected", pre_start_o, 1);
    tick(PRE, 2'd3, 1'b0);
    chk("R12 other-bank precharge legal", illegal_o, 0);
    tick(RD, 2'd1, 1'b0);
    chk("R12 other-bank read later legal", illegal_o, 0);
    tick(WR, 2'd0, 1'b0);
    chk("R9 own write while precharging", illegal_o, 1);
  endtask

  task automatic t_plain_read_in_rdap();
    do_reset();
    open_and_read_close();
    tick(RD, 2'd0, 1'b0);
    chk("R9 plain read during read-close", illegal_o, 1);
    chk("R9 close proceeds", state_o, S_PRE);
  endtask

  task automatic t_active_cmds();
    do_reset();
    tick(ACT, 2'd0, 1'b0);
    wait_to(3);
    tick(ACT, 2'd0, 1'b0);
    chk("R4 activate in active", illegal_o, 1);
    chk("R4 still active", state_o, S_ACTV);
    tick(WR, 2'd0, 1'b0);
    chk("R4 plain write legal", illegal_o, 0);
    chk("R4 active after write", state_o, S_ACTV);
    tick(RD, 2'd0, 1'b0);
    chk("R4 active after read", state_o, S_ACTV);
    tick(PRE, 2'd0, 1'b0);
    chk("R4 explicit precharge", state_o, S_PRE);
    chk("R4 no start pulse", pre_start_o, 0);
    wait_to(10);
    chk("R4 idle after explicit close", state_o, S_IDLE);
  endtask

  task automatic t_mid_reset();
    do_reset();
    tick(ACT, 2'd0, 1'b0);
    wait_to(4);
    tick(ACT, 2'd0, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R13 reset from active", state_o, S_IDLE);
    chk("R13 flag cleared", illegal_o, 0);
  endtask

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_idle();
    t_rcd_and_ras();
    t_write_close();
    t_interrupt();
    t_other_bank_col();
    t_other_bank_free();
    t_plain_read_in_rdap();
    t_active_cmds();
    t_mid_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule